// File: doc/BRIEF.md
# Four-Phase Oversampled Fine Delay Line

This block sits behind a four-phase oversampling capture stage. On every slow clock it receives one word per channel holding four consecutive samples, taken a quarter clock period apart. It delays every channel by a programmable number of fine sample periods, so the delay resolution is one quarter of the clock period. The block also reports, per channel, whether the incoming samples changed level and where the first change falls.

The programmed delay splits into two parts. The upper bits give a whole number of slow cycles, read from a circular history of past input words. The two low bits give a sub-cycle offset, which takes a four-sample window across two adjacent words. The edge finder looks at the last sample of the previous word and the four current samples. Its results leave the block registered, in step with the delayed data.

Top module: `fourphase_delay`

## Requirements
- R1: A synchronous active-high reset clears out_word, out_valid, edge_flag, edge_pos and the whole history. Samples from before the reset, and samples never captured, read as 0.
- R2: Word layout. Bit 4*c+k of a word is sample k of channel c, and k=0 is the earliest sample. Word t (counted from 0 after reset) carries stream samples 4t..4t+3. The delay value D=dly splits as W=D>>2 (whole words) and F=D&3 (quarter cycles).
- R3: With dly=0, out_word in the cycle after an input word equals that word, and out_valid is high.
- R4: With F=0 and W>0, out_word in the cycle after word t equals input word t-W.
- R5: With F>0, output bit 4*c+k in the cycle after word t equals stream sample 4t+k-D of channel c. This window spans words t-W-1 and t-W.
- R6: The largest delay, 4*2^(DLY_W-2)-1 samples, is supported and reaches back 2^(DLY_W-2) words.
- R7: out_valid in the cycle after word t is high exactly when t >= W + (F != 0), with t counted in words since reset.
- R8: A new dly value takes effect on the very next word, with no reset. Its data comes from the history already captured.
- R9: edge_flag[c] is high in the cycle after word t exactly when two consecutive samples of channel c differ, among sample 4t-1 and samples 4t..4t+3.
- R10: edge_pos[2c+1:2c] gives the lowest k for which sample 4t+k differs from sample 4t+k-1. It is 0 when edge_flag[c] is low.
- R11: For the first word after reset, the previous sample used by the edge finder is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sample-word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 4*NCH | Four samples per channel, layout per R2 |
| dly | input | DLY_W | Delay in quarter-cycle sample periods |
| out_word | output | 4*NCH | Delayed samples, same layout |
| out_valid | output | 1 | History covers the selected delay |
| edge_flag | output | NCH | Level change seen per channel |
| edge_pos | output | 2*NCH | Index of first change per channel |

## Verification
The bench sweeps every delay value of a two-channel, five-bit-delay build from reset. It compares each output sample against a sample-stream model, so an off-by-one in the sub-word window shows up as one sample shifted or taken from the wrong word. The largest delay reads the history slot that is overwritten in the same cycle. A buffer one word too short, or a read after the write, would return fresh data in place of the oldest word. The valid threshold is checked at every word, which catches a design that ignores the extra word a nonzero sub-cycle offset needs. The edge finder gets constant words, alternating words and changes that sit only at the word boundary. A design that left out the carried-in sample, or gave the wrong priority, would miss those boundary edges or report the wrong index.

// File: rtl/fourphase_delay.sv
module fourphase_delay #(
  parameter int NCH   = 32,
  parameter int DLY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4*NCH-1:0]   in_word,
  input  logic [DLY_W-1:0]   dly,
  output logic [4*NCH-1:0]   out_word,
  output logic               out_valid,
  output logic [NCH-1:0]     edge_flag,
  output logic [2*NCH-1:0]   edge_pos
);
  localparam int WW    = DLY_W - 2;
  localparam int DEPTH = 1 << WW;
  localparam int WL    = 4 * NCH;
  localparam int FW    = WW + 1;

  logic [WL-1:0] hist [DEPTH];
  logic [WW-1:0] wp;
  logic [FW-1:0] fill;

  logic [WW-1:0] whole;
  logic [1:0]    frac;
  logic [FW-1:0] need;
  logic [WW-1:0] ra, rb, rp;
  logic [WL-1:0] cur_a, old_b, prev_w, shifted;
  logic [NCH-1:0]   eflag_n;
  logic [2*NCH-1:0] epos_n;

  assign whole  = dly[DLY_W-1:2];
  assign frac   = dly[1:0];
  assign need   = {1'b0, whole} + {{WW{1'b0}}, |frac};
  assign ra     = wp - whole;
  assign rb     = ra - WW'(1);
  assign rp     = wp - WW'(1);
  assign cur_a  = (whole == '0) ? in_word : hist[ra];
  assign old_b  = hist[rb];
  assign prev_w = hist[rp];

  always_comb begin
    shifted = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) begin
        if (k >= int'(frac))
          shifted[4*c+k] = cur_a[4*c + k - int'(frac)];
        else
          shifted[4*c+k] = old_b[4*c + k + 4 - int'(frac)];
      end
    end
  end

  always_comb begin
    eflag_n = '0;
    epos_n  = '0;
    for (int c = 0; c < NCH; c++) begin
      logic [4:0] chain;
      logic [3:0] dif;
      chain = {in_word[4*c +: 4], prev_w[4*c+3]};
      dif   = chain[4:1] ^ chain[3:0];
      eflag_n[c] = |dif;
      if (dif[0])      epos_n[2*c +: 2] = 2'd0;
      else if (dif[1]) epos_n[2*c +: 2] = 2'd1;
      else if (dif[2]) epos_n[2*c +: 2] = 2'd2;
      else if (dif[3]) epos_n[2*c +: 2] = 2'd3;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      wp        <= '0;
      fill      <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
      edge_flag <= '0;
      edge_pos  <= '0;
    end else begin
      hist[wp]  <= in_word;
      wp        <= wp + WW'(1);
      if (fill != FW'(DEPTH)) fill <= fill + FW'(1);
      out_word  <= shifted;
      out_valid <= (fill >= need);
      edge_flag <= eflag_n;
      edge_pos  <= epos_n;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && edge_flag == '0 && out_word == '0)); // R1

  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
    (dly == '0) |=> (out_valid && out_word == $past(in_word))); // R3

  AST_FIRST_WORD_INVALID: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && dly == DLY_W'(4)) |=> !out_valid); // R7

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_NO_EDGE_FLAT: assert property (@(posedge clk) disable iff (rst)
      (in_word[4*c +: 4] == {4{prev_w[4*c+3]}}) |=> !edge_flag[c]); // R9
    AST_EDGE_SEEN: assert property (@(posedge clk) disable iff (rst)
      (in_word[4*c +: 4] != {4{prev_w[4*c+3]}}) |=> edge_flag[c]); // R9
  end
endmodule

// File: tb/fourphase_delay_tb_top.sv
module fourphase_delay_tb_top;
  localparam int NCH  = 2;
  localparam int DW   = 5;
  localparam int WL   = 4 * NCH;
  localparam int MAXS = 4 * 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic [WL-1:0]  in_word = '0;
  logic [DW-1:0]  dly = '0;
  logic [WL-1:0]  out_word;
  logic           out_valid;
  logic [NCH-1:0] edge_flag;
  logic [2*NCH-1:0] edge_pos;

  fourphase_delay #(.NCH(NCH), .DLY_W(DW)) dut_i (
    .clk(clk), .rst(rst), .in_word(in_word), .dly(dly),
    .out_word(out_word), .out_valid(out_valid),
    .edge_flag(edge_flag), .edge_pos(edge_pos));

  int checks = 0;
  int fails  = 0;
  int t = 0;
  bit strm [NCH][MAXS];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s word=%0d act=%0h exp=%0h", req, t, act, exp);
    end
  endtask

  function automatic bit smp(input int c, input int idx);
    return (idx < 0) ? 1'b0 : strm[c][idx];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_word = '1;
    @(posedge clk);
    #5;
    chk(out_word == '0, "R1 out_word", out_word, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(edge_flag == '0 && edge_pos == '0, "R1 edge", {edge_flag, edge_pos}, 0);
    t = 0;
  endtask

  task automatic step(input logic [WL-1:0] w, input int d, input string dtag);
    logic [WL-1:0] eo;
    logic [NCH-1:0] ef;
    logic [2*NCH-1:0] ep;
    bit ev;
    @(negedge clk);
    rst = 1'b0;
    in_word = w;
    dly = DW'(d);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++) strm[c][4*t+k] = w[4*c+k];
    @(posedge clk);
    #5;
    eo = '0; ef = '0; ep = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) eo[4*c+k] = smp(c, 4*t + k - d);
      for (int k = 3; k >= 0; k--)
        if (smp(c, 4*t+k) != smp(c, 4*t+k-1)) begin
          ef[c] = 1'b1;
          ep[2*c +: 2] = 2'(k);
        end
    end
    ev = (t >= (d >> 2) + (((d & 3) != 0) ? 1 : 0));
    chk(out_word == eo, dtag, out_word, eo);
    chk(out_valid == ev, "R7 valid", out_valid, ev);
    chk(edge_flag == ef, (t == 0) ? "R11 R9 flag" : "R9 flag", edge_flag, ef);
    chk(edge_pos == ep, "R10 pos", edge_pos, ep);
    t++;
  endtask

  function automatic logic [WL-1:0] pat(input int i);
    case (i % 8)
      0: return '0;
      1: return '1;
      2: return WL'(8'h5A);
      3: return WL'(8'h80);
      4: return WL'(8'h01);
      default: return WL'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 32; d++) begin
      string tag;
      if (d == 0) tag = "R3 zero delay";
      else if (d == 31) tag = "R6 max delay";
      else if ((d & 3) == 0) tag = "R4 whole delay";
      else tag = "R5 fine delay";
      do_reset();
      for (int i = 0; i < 40; i++) step(pat(i + d), d, tag);
    end
    do_reset();
    for (int i = 0; i < 120; i++) step(pat(i), ((i / 5) * 7) % 32, "R8 delay change");
    do_reset();
    for (int i = 0; i < 12; i++) step(WL'(8'hF0) ^ (i[0] ? '1 : '0), 0, "R2 layout");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule